// File: doc/BRIEF.md
# TDM Channel Router with Selectable Control Source

This block relays five 8-bit timeslots per frame between a time-division backplane port and a line-side transceiver. The slots carry two bearer channels (B1, B2), a signalling channel (D), a control channel (C) and a status slot. For each direction, every bearer and signalling slot is gated by its own bit in a port control byte. A gated-off slot is sent as all ones. The status slot is relayed without gating. On its way to the backplane, the C slot always carries a local mode status byte. On its way to the line, the C slot is always all ones.

Control of the router comes from one of two sources: the register write port, or the C bytes received from the backplane. A mode pin decides how that choice is made. In processor mode a bit in a master control byte makes the choice. In standalone mode an external select pin makes it. The mode pin also sets the reset state of the paths: open in standalone mode, closed in processor mode. The processor can replace the byte relayed in any bearer, signalling or status slot for one frame. All control changes wait for the next frame boundary, so a slot is never sent half-updated.

Frame and slot timing come in on strobes. Serial shifting, line coding and packet framing happen elsewhere.

Top module: `tdm_router`

## Requirements
- R1: After reset with `mode_proc`=0, the effective port control `ctl_eff` is 0x77, so all B1, B2 and D slots are relayed in both directions.
- R2: After reset with `mode_proc`=1, `ctl_eff` is 0x00, and every B1, B2 and D slot is sent as 0xFF in both directions.
- R3: Port control bit mapping:
  - Toward the line: bit 0 enables D, bit 1 enables B1 and bit 2 enables B2.
  - Toward the backplane: bit 4 enables D, bit 5 enables B1 and bit 6 enables B2.
  - A disabled slot is sent as 0xFF.
  - Slot indices are B1=0, B2=1, D=2, C=3, status=4.
- R4: A change to the port control, the master control, the control-source choice or the C-derived control becomes active at the `frame_sync` edge that follows it, and not before.
- R5: Control-source selection:
  - In processor mode, bit 0 of the master control byte (address 0x01) selects the source: 1 for the C slot, 0 for the register port.
  - In standalone mode, the `ext_csel` pin selects it, with the same meaning.
  - The master control byte is writable only in processor mode, and writable whatever the source.
- R6: While the C slot is the source:
  - Each received C byte becomes the effective port control at the next frame boundary.
  - Register writes to the port control (address 0x00) and to the override registers are ignored.
- R7: While the register port is the source, received C bytes are discarded. The C-derived control keeps its last value.
- R8: The C slot sent toward the backplane carries `nt_status` when `nt_mode`=1 and `te_status` when `nt_mode`=0. It is never gated.
- R9: One-shot override:
  - A write to address 0x10+slot (toward the line) or 0x18+slot (toward the backplane) replaces that slot's outgoing byte in the next frame only.
  - The override takes effect even when the slot is gated off.
  - Writes for the C slot are ignored.
  - The status slot is relayed without gating.
  - The C slot toward the line is always 0xFF.
- R10: Every slot strobe gives, one clock later, `tx_vld`=1 with `tx_slot` equal to the strobed index and both output bytes updated. Without a strobe, `tx_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_proc | input | 1 | 1 = processor mode, 0 = standalone mode |
| nt_mode | input | 1 | Selects which status byte goes out in the C slot |
| ext_csel | input | 1 | Standalone control-source select (1 = C slot) |
| frame_sync | input | 1 | One-cycle frame boundary pulse |
| slot_vld | input | 1 | Slot strobe |
| slot_idx | input | 3 | Index of the strobed slot (0..4) |
| tdm_rx_data | input | 8 | Byte received from the backplane |
| line_rx_data | input | 8 | Byte received from the line side |
| nt_status | input | 8 | Network-side mode status byte |
| te_status | input | 8 | Terminal-side mode status byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| tx_vld | output | 1 | Output bytes valid |
| tx_slot | output | 3 | Slot index of the output bytes |
| tdm_tx_data | output | 8 | Byte sent to the backplane |
| line_tx_data | output | 8 | Byte sent to the line side |
| ctl_eff | output | 8 | Effective port control in force this frame |

## Verification
The assertions assume the following about the inputs:
- `frame_sync` and `slot_vld` are never high in the same cycle.
- `slot_idx` stays within 0..4.
- `mode_proc` changes only while reset is held.
- No register write coincides with a frame boundary.

The stimulus respects all of these:
- Slots are strobed on separate cycles after a one-cycle frame pulse.
- Mode changes are made only inside a reset sequence.
- Register writes fall between the slots of a frame.

With these assumptions, the timing of `tx_vld`, the C-slot contents and the once-per-frame stability of `ctl_eff` can be checked on every cycle.

// File: rtl/tdm_router_pkg.sv
// Package: shared constants and slot encoding for the TDM channel router.
// Assumes a five-slot frame with 8-bit slots.
package tdm_router_pkg;
    localparam int DATA_W  = 8;
    localparam int NSLOT   = 5;
    localparam int IDX_W   = $clog2(NSLOT);
    localparam int ADDR_W  = 5;
    localparam int NDIR    = 2;

    // Slot indices within a frame
    localparam logic [IDX_W-1:0] SLOT_B1   = 3'd0;
    localparam logic [IDX_W-1:0] SLOT_B2   = 3'd1;
    localparam logic [IDX_W-1:0] SLOT_D    = 3'd2;
    localparam logic [IDX_W-1:0] SLOT_C    = 3'd3;
    localparam logic [IDX_W-1:0] SLOT_STAT = 3'd4;

    // Register map
    localparam logic [ADDR_W-1:0] ADDR_PCTL = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_MCTL = 5'h01;

    localparam logic [DATA_W-1:0] IDLE_BYTE    = '1;
    localparam logic [DATA_W-1:0] OPEN_DEFAULT = 8'h77;
    localparam logic [DATA_W-1:0] SHUT_DEFAULT = 8'h00;

    // Control-byte bit for a given direction (0 = to line, 1 = to backplane)
    // and channel offset (0 = D, 1 = B1, 2 = B2).
    function automatic int ctl_bit(input int dir, input int chan);
        return dir * 4 + chan;
    endfunction
endpackage

// File: rtl/tdm_router_regs.sv
// Module: control store of the router. Holds pending and active copies of
// the port control, master source bit, C-derived control and the one-shot
// overrides, and commits pending to active on frame_sync.
// Assumes: frame_sync never coincides with reg_wr; mode_proc is static
// outside reset.
module tdm_router_regs
    import tdm_router_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 mode_proc,
    input  logic                                 ext_csel,
    input  logic                                 frame_sync,
    input  logic                                 slot_vld,
    input  logic [IDX_W-1:0]                     slot_idx,
    input  logic [DATA_W-1:0]                    c_rx_byte,
    input  logic                                 reg_wr,
    input  logic [ADDR_W-1:0]                    reg_addr,
    input  logic [DATA_W-1:0]                    reg_wdata,
    output logic [DATA_W-1:0]                    ctl_eff,
    output logic [NDIR-1:0][NSLOT-1:0]           ov_vld,
    output logic [NDIR-1:0][NSLOT-1:0][DATA_W-1:0] ov_val
);
    logic [DATA_W-1:0] reset_ctl;
    logic [DATA_W-1:0] pctl_pend, pctl_act;
    logic [DATA_W-1:0] cctl_pend, cctl_act;
    logic              msrc_pend;
    logic              csel_act;
    logic [NDIR-1:0][NSLOT-1:0]             ov_pend_vld;
    logic [NDIR-1:0][NSLOT-1:0][DATA_W-1:0] ov_pend_val;

    logic              port_ok;
    logic              wr_pctl, wr_mctl, wr_ov, c_load;
    logic              ov_dir;
    logic [IDX_W-1:0]  ov_slot;

    // Purpose: reset value of the path controls follows the mode pin
    assign reset_ctl = mode_proc ? SHUT_DEFAULT : OPEN_DEFAULT;

    // Purpose: decode register writes and C-slot capture
    always_comb begin
        port_ok = !csel_act;
        ov_dir  = reg_addr[3];
        ov_slot = reg_addr[IDX_W-1:0];
        wr_pctl = reg_wr && port_ok && (reg_addr == ADDR_PCTL);
        wr_mctl = reg_wr && mode_proc && (reg_addr == ADDR_MCTL);
        wr_ov   = reg_wr && port_ok && reg_addr[4]
                  && (ov_slot < IDX_W'(NSLOT)) && (ov_slot != SLOT_C);
        c_load  = slot_vld && (slot_idx == SLOT_C) && csel_act;
    end

    // Purpose: pending port/master/C-derived controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pctl_pend <= reset_ctl;
            cctl_pend <= reset_ctl;
            msrc_pend <= 1'b0;
        end else begin
            if (wr_pctl) pctl_pend <= reg_wdata;
            if (wr_mctl) msrc_pend <= reg_wdata[0];
            if (c_load)  cctl_pend <= c_rx_byte;
        end
    end

    // Purpose: active controls change only at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pctl_act <= reset_ctl;
            cctl_act <= reset_ctl;
            csel_act <= mode_proc ? 1'b0 : ext_csel;
        end else if (frame_sync) begin
            pctl_act <= pctl_pend;
            cctl_act <= cctl_pend;
            csel_act <= mode_proc ? msrc_pend : ext_csel;
        end
    end

    // Purpose: one-shot overrides, armed for exactly the next frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_pend_vld <= '0;
            ov_pend_val <= '0;
            ov_vld      <= '0;
            ov_val      <= '0;
        end else begin
            if (frame_sync) begin
                ov_vld      <= ov_pend_vld;
                ov_val      <= ov_pend_val;
                ov_pend_vld <= '0;
            end
            if (wr_ov) begin
                ov_pend_vld[ov_dir][ov_slot] <= 1'b1;
                ov_pend_val[ov_dir][ov_slot] <= reg_wdata;
            end
        end
    end

    // Purpose: choose the control byte in force this frame
    assign ctl_eff = csel_act ? cctl_act : pctl_act;
endmodule

// File: rtl/tdm_router_lane.sv
// Module: one relay direction. Registers the outgoing byte for each slot
// strobe, applying override, gating and the fixed C-slot content.
// Assumes slot_idx is within the frame when slot_vld is high.
module tdm_router_lane
    import tdm_router_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          slot_vld,
    input  logic [IDX_W-1:0]              slot_idx,
    input  logic [DATA_W-1:0]             src_byte,
    input  logic [2:0]                    chan_en,   // {B2, B1, D}
    input  logic [DATA_W-1:0]             c_byte,
    input  logic [NSLOT-1:0]              ov_vld,
    input  logic [NSLOT-1:0][DATA_W-1:0]  ov_val,
    output logic [DATA_W-1:0]             tx_byte
);
    logic [DATA_W-1:0] nxt;

    // Purpose: select the outgoing byte for the strobed slot
    always_comb begin
        nxt = IDLE_BYTE;
        if (slot_idx < IDX_W'(NSLOT) && ov_vld[slot_idx]) begin
            nxt = ov_val[slot_idx];
        end else begin
            case (slot_idx)
                SLOT_D:    nxt = chan_en[0] ? src_byte : IDLE_BYTE;
                SLOT_B1:   nxt = chan_en[1] ? src_byte : IDLE_BYTE;
                SLOT_B2:   nxt = chan_en[2] ? src_byte : IDLE_BYTE;
                SLOT_C:    nxt = c_byte;
                SLOT_STAT: nxt = src_byte;
                default:   nxt = IDLE_BYTE;
            endcase
        end
    end

    // Purpose: register the slot byte
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_byte <= IDLE_BYTE;
        else if (slot_vld) tx_byte <= nxt;
    end
endmodule

// File: rtl/tdm_router.sv
// Module: top of the TDM channel router. Two relay lanes share one control
// store. Lane 0 runs backplane -> line, lane 1 runs line -> backplane.
// Assumes frame_sync and slot_vld are never high together.
module tdm_router
    import tdm_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_proc,
    input  logic              nt_mode,
    input  logic              ext_csel,
    input  logic              frame_sync,
    input  logic              slot_vld,
    input  logic [2:0]        slot_idx,
    input  logic [7:0]        tdm_rx_data,
    input  logic [7:0]        line_rx_data,
    input  logic [7:0]        nt_status,
    input  logic [7:0]        te_status,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              tx_vld,
    output logic [2:0]        tx_slot,
    output logic [7:0]        tdm_tx_data,
    output logic [7:0]        line_tx_data,
    output logic [7:0]        ctl_eff
);
    logic [NDIR-1:0][NSLOT-1:0]             ov_vld;
    logic [NDIR-1:0][NSLOT-1:0][DATA_W-1:0] ov_val;
    logic [NDIR-1:0][DATA_W-1:0]            lane_src, lane_c, lane_out;
    logic [NDIR-1:0][2:0]                   lane_en;
    logic [DATA_W-1:0]                      status_sel;

    tdm_router_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_proc (mode_proc),
        .ext_csel  (ext_csel),
        .frame_sync(frame_sync),
        .slot_vld  (slot_vld),
        .slot_idx  (slot_idx),
        .c_rx_byte (tdm_rx_data),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ctl_eff   (ctl_eff),
        .ov_vld    (ov_vld),
        .ov_val    (ov_val)
    );

    // Purpose: pick the mode status byte returned in the C slot
    assign status_sel = nt_mode ? nt_status : te_status;

    // Purpose: per-direction sources, enables and C-slot content
    assign lane_src[0] = tdm_rx_data;
    assign lane_src[1] = line_rx_data;
    assign lane_c[0]   = IDLE_BYTE;
    assign lane_c[1]   = status_sel;

    for (genvar d = 0; d < NDIR; d++) begin : g_lane
        assign lane_en[d] = {ctl_eff[ctl_bit(d, 2)], ctl_eff[ctl_bit(d, 1)],
                             ctl_eff[ctl_bit(d, 0)]};
        tdm_router_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .slot_vld(slot_vld),
            .slot_idx(slot_idx),
            .src_byte(lane_src[d]),
            .chan_en (lane_en[d]),
            .c_byte  (lane_c[d]),
            .ov_vld  (ov_vld[d]),
            .ov_val  (ov_val[d]),
            .tx_byte (lane_out[d])
        );
    end

    assign line_tx_data = lane_out[0];
    assign tdm_tx_data  = lane_out[1];

    // Purpose: output strobe and slot tag, aligned with the lane registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_vld  <= 1'b0;
            tx_slot <= '0;
        end else begin
            tx_vld  <= slot_vld;
            if (slot_vld) tx_slot <= slot_idx;
        end
    end
endmodule

// File: rtl/tdm_router_chk.sv
// Module: assertion checker bound to tdm_router. Assumes the input rules
// stated in the brief (no slot strobe on a frame pulse, indices 0..4).
module tdm_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nt_mode,
    input logic       frame_sync,
    input logic       slot_vld,
    input logic [2:0] slot_idx,
    input logic [7:0] nt_status,
    input logic [7:0] te_status,
    input logic       tx_vld,
    input logic [2:0] tx_slot,
    input logic [7:0] tdm_tx_data,
    input logic [7:0] line_tx_data,
    input logic [7:0] ctl_eff
);
    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> (tx_vld && tx_slot == $past(slot_idx)));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_vld |=> !tx_vld);

    p_c_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && slot_idx == 3'd3) |=>
        (tdm_tx_data == ($past(nt_mode) ? $past(nt_status) : $past(te_status))));

    p_line_c_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && slot_idx == 3'd3) |=> (line_tx_data == 8'hFF));

    p_frame_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(ctl_eff));
endmodule

bind tdm_router tdm_router_chk u_chk (.*);

// File: tb/tdm_router_bench.sv
module tdm_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_proc = 1'b0, nt_mode = 1'b1, ext_csel = 1'b0;
    logic       frame_sync = 1'b0, slot_vld = 1'b0;
    logic [2:0] slot_idx = '0;
    logic [7:0] tdm_rx_data = '0, line_rx_data = '0;
    logic [7:0] nt_status = 8'h4E, te_status = 8'h7E;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       tx_vld;
    logic [2:0] tx_slot;
    logic [7:0] tdm_tx_data, line_tx_data, ctl_eff;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] slot;
        logic [7:0] tdm;
        logic [7:0] line;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_router u_tdm_router (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per output strobe
    always @(negedge clk) begin
        if (rst_n && tx_vld) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected tx_vld", 8'(tx_slot), 8'h00);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(tx_slot == e.slot, "R10", "tx_slot", 8'(tx_slot), 8'(e.slot));
                check(tdm_tx_data == e.tdm, e.tag, "tdm_tx_data", tdm_tx_data, e.tdm);
                check(line_tx_data == e.line, e.tag, "line_tx_data", line_tx_data, e.line);
            end
        end
    end

    task automatic do_reset(input logic proc);
        rst_n = 1'b0;
        mode_proc = proc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_frame();
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: one slot strobe, pushes its expected outputs
    task automatic send_slot(input logic [2:0] idx, input logic [7:0] tin,
                             input logic [7:0] lin, input logic [7:0] etdm,
                             input logic [7:0] eline, input string tag);
        exp_t e;
        e.slot = idx; e.tdm = etdm; e.line = eline; e.tag = tag;
        sb.push_back(e);
        slot_vld = 1'b1; slot_idx = idx; tdm_rx_data = tin; line_rx_data = lin;
        @(negedge clk);
        slot_vld = 1'b0;
    endtask

    // Five slots with no override, expected from a control byte
    task automatic send_frame(input logic [7:0] ctl, input logic [7:0] cin,
                              input logic [7:0] base, input string tag);
        logic [7:0] st;
        st = nt_mode ? nt_status : te_status;
        send_slot(3'd0, base, ~base, ctl[5] ? ~base : 8'hFF, ctl[1] ? base : 8'hFF, tag);
        send_slot(3'd1, base+1, ~(base+8'd1), ctl[6] ? ~(base+8'd1) : 8'hFF,
                  ctl[2] ? base+8'd1 : 8'hFF, tag);
        send_slot(3'd2, base+2, ~(base+8'd2), ctl[4] ? ~(base+8'd2) : 8'hFF,
                  ctl[0] ? base+8'd2 : 8'hFF, tag);
        send_slot(3'd3, cin, 8'h5A, st, 8'hFF, "R8");
        send_slot(3'd4, base+4, ~(base+8'd4), ~(base+8'd4), base+8'd4, "R9");
    endtask

    task automatic check_ctl(input logic [7:0] exp, input string tag);
        check(ctl_eff == exp, tag, "ctl_eff", ctl_eff, exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: standalone reset opens paths
        do_reset(1'b0);
        check_ctl(8'h77, "R1");
        check(tx_vld == 1'b0, "R10", "tx_vld after reset", 8'(tx_vld), 8'h00);
        pulse_frame();
        send_frame(8'h77, 8'h00, 8'h10, "R1");

        // R4: write waits for frame boundary
        wr(5'h00, 8'h21);
        check_ctl(8'h77, "R4");
        send_frame(8'h77, 8'h00, 8'h20, "R4");
        pulse_frame();
        check_ctl(8'h21, "R4");

        // R3: several gating patterns
        send_frame(8'h21, 8'h00, 8'h30, "R3");
        wr(5'h00, 8'h10); pulse_frame(); send_frame(8'h10, 8'h00, 8'h40, "R3");
        wr(5'h00, 8'h44); pulse_frame(); send_frame(8'h44, 8'h00, 8'h50, "R3");
        wr(5'h00, 8'h03); pulse_frame(); send_frame(8'h03, 8'h00, 8'h60, "R3");

        // R8: status follows nt_mode
        nt_mode = 1'b0;
        send_frame(8'h03, 8'h00, 8'h70, "R8");
        nt_mode = 1'b1;

        // R9: one-shot override wins over closed gating
        wr(5'h00, 8'h00);
        wr(5'h10, 8'hA5);   // toward line, B1
        wr(5'h1C, 8'h3C);   // toward backplane, status slot
        wr(5'h1B, 8'h99);   // C slot: ignored
        pulse_frame();
        send_slot(3'd0, 8'h01, 8'h02, 8'hFF, 8'hA5, "R9");
        send_slot(3'd1, 8'h03, 8'h04, 8'hFF, 8'hFF, "R9");
        send_slot(3'd3, 8'h00, 8'h05, 8'h4E, 8'hFF, "R9");
        send_slot(3'd4, 8'h06, 8'h07, 8'h3C, 8'h06, "R9");
        pulse_frame();
        send_slot(3'd0, 8'h11, 8'h12, 8'hFF, 8'hFF, "R9");
        send_slot(3'd4, 8'h16, 8'h17, 8'h17, 8'h16, "R9");

        // R5/R6: standalone, C slot chosen by pin
        wr(5'h00, 8'h02); pulse_frame(); check_ctl(8'h02, "R5");
        ext_csel = 1'b1;
        pulse_frame();
        check_ctl(8'h77, "R6");
        wr(5'h00, 8'h00);           // ignored
        wr(5'h12, 8'hCC);           // override ignored
        send_frame(8'h77, 8'h05, 8'h80, "R6");
        check_ctl(8'h77, "R4");
        pulse_frame();
        check_ctl(8'h05, "R6");
        send_frame(8'h05, 8'h05, 8'h90, "R6");

        // R7: register source, C byte discarded
        ext_csel = 1'b0;
        pulse_frame();
        check_ctl(8'h02, "R6");
        send_frame(8'h02, 8'h00, 8'hA0, "R7");
        pulse_frame();
        check_ctl(8'h02, "R7");
        ext_csel = 1'b1;
        pulse_frame();
        check_ctl(8'h05, "R7");
        ext_csel = 1'b0;

        // R2: processor mode resets closed
        do_reset(1'b1);
        check_ctl(8'h00, "R2");
        pulse_frame();
        send_frame(8'h00, 8'h00, 8'hB0, "R2");
        wr(5'h00, 8'h77); pulse_frame(); check_ctl(8'h77, "R5");

        // R5: master bit picks C slot, writable while C is source
        ext_csel = 1'b1;            // no effect in processor mode
        pulse_frame();
        check_ctl(8'h77, "R5");
        wr(5'h01, 8'h01); pulse_frame(); check_ctl(8'h00, "R5");
        send_frame(8'h00, 8'h70, 8'hC0, "R6");
        pulse_frame();
        check_ctl(8'h70, "R6");
        wr(5'h01, 8'h00); pulse_frame(); check_ctl(8'h77, "R5");
        send_frame(8'h77, 8'h00, 8'hD0, "R5");

        @(negedge clk);
        check(sb.size() == 0, "R10", "pending expected items", 8'(sb.size()), 8'h00);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule